// File: doc/BRIEF.md
# Register-Driven I2C Master

This block is an I2C master that moves one byte per software step. Software programs four small registers: a control word, a status word, a target byte and a data byte. It then asks for a START. The engine drives SCL and SDA as open-drain pins. An output of 1 pulls the wire low, and an output of 0 releases it. At the end of each phase the engine raises a status flag and holds SCL low. The bus stays stalled until software writes a zero to that flag.

Bit timing does not come from inside the block. An external one-cycle `tick` pulse advances the engine by one quarter of an SCL period. A slower or faster tick therefore sets the bus rate. The engine handles write and read transfers, repeated START, STOP on request, NACK detection and loss of arbitration. A pin-override mode lets software drive both wires directly, and the engine stays frozen while that mode is on.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, the status word reads 0, the data byte reads 0, and both `scl_oe` and `sda_oe` are 0, so both wires are released.
- R2: `reg_sel` selects a register: 0 control, 1 status, 2 target, 3 data. The control bits are: bit 6 the SCL level, bit 5 the SDA level, bit 4 override, bit 3 enable, bit 1 stop request, bit 0 start request. Bits 7 and 2 have no effect. The target byte holds the 7-bit address in bits 7:1 and the direction in bit 0, where 1 means read.
- R3: A control write with both enable and start set issues a START and then shifts out the target byte, MSB first. In a write transfer, the first data byte sent is the current value of the data register.
- R4: The status bits are: 6 NACK, 5 arbitration lost, 4 STOP sent, 3 data register empty, 2 byte sent, 1 byte received, 0 address done. When a write-direction address is ACKed, bits 0 and 3 are set. When a read-direction address is ACKed, bits 0 and 1 are set. In both cases SCL is held low.
- R5: When a data byte in a write is ACKed, bits 2 and 3 are set.
- R6: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. SCL stays low while bit 0, 1 or 3 is set. Once all three are clear, the transfer resumes.
- R7: If the stop request is set when the last pending flag is cleared, the engine sends a STOP and then sets bit 4.
- R8: A start request made while the engine holds the bus produces a repeated START with the target byte, and no STOP comes before it. Without a new request, a transfer continues with no new START.
- R9: In a read, the engine shifts the byte in MSB first, stores it in the data register and sets bit 1. It ACKs the byte, or NACKs it if the stop request is set when the byte is released. The release that follows a NACKed byte sends a STOP.
- R10: A NACK on an address or data byte sets bit 6, then the engine sends a STOP and sets bit 4.
- R11: If SDA reads low while the engine is releasing it during an outgoing bit, bit 5 is set, both wires are released, the engine returns to idle and bit 4 stays clear.
- R12: While override is set, `scl_oe` is the inverse of the SCL-level bit and `sda_oe` is the inverse of the SDA-level bit, and the engine is frozen.
- R13: Writing 0 to the control register releases both wires in the cycle the register updates and returns the engine to idle. After that, no status flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Quarter-bit advance pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status_o | output | 7 | Status flags |
| data_o | output | 8 | Data register (last received byte) |

## Verification
- A register write takes effect at the clock edge that follows the strobe. Override and clear-to-zero show on the pins in that same cycle, so the bench checks pins at the falling edge just after its write returns.
- A phase flag appears one clock after the quarter-tick that ends the phase, and it stays set until it is cleared. The bench therefore polls for each flag on falling edges, with a bound on how long it waits, and compares the whole status word only after the flag has appeared.
- An abort or an arbitration loss should raise no further flag, so the bench waits a few hundred cycles before checking that the status word has not changed.

// File: rtl/i2cm_pkg.sv
// Shared constants and types for the register-driven I2C master.
// Assumes an 8-bit register bus and a 7-bit status word.
package i2cm_pkg;
    localparam int REG_W  = 8;
    localparam int STAT_W = 7;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    // Control bit positions
    localparam int C_SCL   = 6;
    localparam int C_SDA   = 5;
    localparam int C_OVR   = 4;
    localparam int C_EN    = 3;
    localparam int C_STOP  = 1;
    localparam int C_START = 0;

    // Status bit positions
    localparam int S_NACK  = 6;
    localparam int S_ARB   = 5;
    localparam int S_STOP  = 4;
    localparam int S_EMPTY = 3;
    localparam int S_SENT  = 2;
    localparam int S_RECV  = 1;
    localparam int S_ADDR  = 0;

    // Engine phases
    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_TX,
        E_RX,
        E_HOLD,
        E_STOP
    } eng_state_e;
endpackage

// File: rtl/i2cm_regs.sv
// Register file of the I2C master: control fields, target byte, data byte,
// status word with write-zero-to-clear, and a one-shot start request.
// Assumes the engine's set pulses and receive strobe are single-cycle.
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] set_mask,
    input  logic              rx_we,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              start_take,
    output logic              en_o,
    output logic              stop_o,
    output logic              ovr_o,
    output logic              fscl_o,
    output logic              fsda_o,
    output logic              start_req_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [STAT_W-1:0] status_o
);
    logic              wr_ctrl, wr_stat, wr_addr, wr_data;
    logic [STAT_W-1:0] stat_nxt;

    // Decode the write strobe per register
    always_comb begin
        wr_ctrl = we && (sel == SEL_CTRL);
        wr_stat = we && (sel == SEL_STAT);
        wr_addr = we && (sel == SEL_ADDR);
        wr_data = we && (sel == SEL_DATA);
    end

    // Next status: software clears with zeros, engine sets win
    always_comb begin
        stat_nxt = status_o;
        if (wr_stat) stat_nxt = status_o & wdata[STAT_W-1:0];
        stat_nxt = stat_nxt | set_mask;
    end

    // Control fields and start request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o        <= 1'b0;
            stop_o      <= 1'b0;
            ovr_o       <= 1'b0;
            fscl_o      <= 1'b0;
            fsda_o      <= 1'b0;
            start_req_o <= 1'b0;
        end else if (wr_ctrl) begin
            en_o        <= wdata[C_EN];
            stop_o      <= wdata[C_STOP];
            ovr_o       <= wdata[C_OVR];
            fscl_o      <= wdata[C_SCL];
            fsda_o      <= wdata[C_SDA];
            start_req_o <= wdata[C_EN] & wdata[C_START];
        end else if (start_take) begin
            start_req_o <= 1'b0;
        end
    end

    // Target byte, data byte and status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            data_o   <= '0;
            status_o <= '0;
        end else begin
            status_o <= stat_nxt;
            if (wr_addr) addr_o <= wdata;
            if (rx_we)        data_o <= rx_data;
            else if (wr_data) data_o <= wdata;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
// Bit engine of the I2C master: START, byte shift out/in, ACK bit,
// hold with SCL low, repeated START and STOP, one quarter-bit per tick.
// Assumes phase_pend reflects the status word one cycle after set_mask.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              freeze,
    input  logic              stop_req,
    input  logic              start_req,
    input  logic              phase_pend,
    input  logic [DATA_W-1:0] addr_byte,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              sda_in,
    output logic              start_take,
    output logic [STAT_W-1:0] set_mask,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_data,
    output logic              scl_low,
    output logic              sda_low
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

    eng_state_e        state;
    logic [1:0]        q;
    logic [CNT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic              is_addr, dir_rd, rx_nack, ack_n;

    assign rx_data = shreg;

    // Phase sequencer, shifter and line drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= E_IDLE;
            q          <= '0;
            bitn       <= '0;
            shreg      <= '0;
            is_addr    <= 1'b0;
            dir_rd     <= 1'b0;
            rx_nack    <= 1'b0;
            ack_n      <= 1'b0;
            scl_low    <= 1'b0;
            sda_low    <= 1'b0;
            set_mask   <= '0;
            rx_we      <= 1'b0;
            start_take <= 1'b0;
        end else begin
            set_mask   <= '0;
            rx_we      <= 1'b0;
            start_take <= 1'b0;
            if (!enable) begin
                state   <= E_IDLE;
                q       <= '0;
                scl_low <= 1'b0;
                sda_low <= 1'b0;
            end else if (tick && !freeze) begin
                q <= q + 2'd1;
                unique case (state)
                    E_IDLE: begin
                        q       <= '0;
                        scl_low <= 1'b0;
                        sda_low <= 1'b0;
                        if (start_req) begin
                            state      <= E_START;
                            start_take <= 1'b1;
                            shreg      <= addr_byte;
                            dir_rd     <= addr_byte[0];
                            rx_nack    <= 1'b0;
                        end
                    end
                    E_START: begin
                        unique case (q)
                            2'd0: sda_low <= 1'b0;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b1;
                            2'd3: begin
                                scl_low <= 1'b1;
                                state   <= E_TX;
                                is_addr <= 1'b1;
                                bitn    <= '0;
                            end
                        endcase
                    end
                    E_TX: begin
                        unique case (q)
                            2'd0: sda_low <= (bitn == ACK_IDX) ? 1'b0 : ~shreg[DATA_W-1];
                            2'd1: scl_low <= 1'b0;
                            2'd2: begin
                                if (bitn == ACK_IDX) begin
                                    ack_n <= sda_in;
                                end else if (!sda_low && !sda_in) begin
                                    set_mask[S_ARB] <= 1'b1;
                                    state   <= E_IDLE;
                                    q       <= '0;
                                    scl_low <= 1'b0;
                                    sda_low <= 1'b0;
                                end
                            end
                            2'd3: begin
                                scl_low <= 1'b1;
                                if (bitn == ACK_IDX) begin
                                    bitn <= '0;
                                    if (ack_n) begin
                                        set_mask[S_NACK] <= 1'b1;
                                        state <= E_STOP;
                                    end else begin
                                        if (is_addr) begin
                                            set_mask[S_ADDR] <= 1'b1;
                                            if (dir_rd) set_mask[S_RECV]  <= 1'b1;
                                            else        set_mask[S_EMPTY] <= 1'b1;
                                        end else begin
                                            set_mask[S_SENT]  <= 1'b1;
                                            set_mask[S_EMPTY] <= 1'b1;
                                        end
                                        state <= E_HOLD;
                                    end
                                end else begin
                                    shreg <= {shreg[DATA_W-2:0], 1'b0};
                                    bitn  <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                    E_RX: begin
                        unique case (q)
                            2'd0: begin
                                if (bitn == ACK_IDX) begin
                                    sda_low <= ~stop_req;
                                    rx_nack <= stop_req;
                                end else begin
                                    sda_low <= 1'b0;
                                end
                            end
                            2'd1: scl_low <= 1'b0;
                            2'd2: if (bitn != ACK_IDX) shreg <= {shreg[DATA_W-2:0], sda_in};
                            2'd3: begin
                                scl_low <= 1'b1;
                                if (bitn == ACK_IDX) begin
                                    bitn  <= '0;
                                    rx_we <= 1'b1;
                                    set_mask[S_RECV] <= 1'b1;
                                    state <= E_HOLD;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                    E_HOLD: begin
                        q <= '0;
                        if (set_mask == '0 && !phase_pend) begin
                            if (start_req) begin
                                state      <= E_START;
                                start_take <= 1'b1;
                                shreg      <= addr_byte;
                                dir_rd     <= addr_byte[0];
                                rx_nack    <= 1'b0;
                            end else if (dir_rd) begin
                                if (rx_nack) state <= E_STOP;
                                else begin
                                    state <= E_RX;
                                    bitn  <= '0;
                                end
                            end else if (stop_req) begin
                                state <= E_STOP;
                            end else begin
                                state   <= E_TX;
                                is_addr <= 1'b0;
                                shreg   <= data_byte;
                                bitn    <= '0;
                            end
                        end
                    end
                    E_STOP: begin
                        unique case (q)
                            2'd0: sda_low <= 1'b1;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b0;
                            2'd3: begin
                                set_mask[S_STOP] <= 1'b1;
                                state <= E_IDLE;
                            end
                        endcase
                    end
                    default: state <= E_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_master.sv
// Top of the register-driven I2C master: register file, bit engine and the
// pin selector that picks override levels, engine drive, or release.
// Assumes sda_i is already synchronised to clk.
module i2c_reg_master
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [STAT_W-1:0] status_o,
    output logic [REG_W-1:0]  data_o
);
    logic              c_en, c_stop, c_ovr, c_fscl, c_fsda;
    logic              start_req, start_take, rx_we, phase_pend;
    logic              eng_scl_low, eng_sda_low;
    logic [STAT_W-1:0] eng_set;
    logic [REG_W-1:0]  rx_data, addr_q;

    i2cm_regs #(.DATA_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .set_mask(eng_set), .rx_we(rx_we), .rx_data(rx_data), .start_take(start_take),
        .en_o(c_en), .stop_o(c_stop), .ovr_o(c_ovr), .fscl_o(c_fscl), .fsda_o(c_fsda),
        .start_req_o(start_req), .addr_o(addr_q), .data_o(data_o), .status_o(status_o)
    );

    // Flags that stall the bus until software clears them
    assign phase_pend = status_o[S_ADDR] | status_o[S_EMPTY] | status_o[S_RECV];

    i2cm_engine #(.DATA_W(REG_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(c_en), .freeze(c_ovr),
        .stop_req(c_stop), .start_req(start_req), .phase_pend(phase_pend),
        .addr_byte(addr_q), .data_byte(data_o), .sda_in(sda_i),
        .start_take(start_take), .set_mask(eng_set), .rx_we(rx_we), .rx_data(rx_data),
        .scl_low(eng_scl_low), .sda_low(eng_sda_low)
    );

    // Pin selector: override levels, engine drive, or released
    always_comb begin
        if (c_ovr) begin
            scl_oe = ~c_fscl;
            sda_oe = ~c_fsda;
        end else if (c_en) begin
            scl_oe = eng_scl_low;
            sda_oe = eng_sda_low;
        end else begin
            scl_oe = 1'b0;
            sda_oe = 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_checker.sv
// Protocol checks for the I2C master, bound onto the top module.
// Assumes the register and status encodings of i2cm_pkg.
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [STAT_W-1:0] status_o,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              en,
    input logic              ovr,
    input logic [STAT_W-1:0] eng_set
);
    logic pend;
    assign pend = status_o[S_ADDR] | status_o[S_EMPTY] | status_o[S_RECV];

    // R4
    addr_done_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[S_ADDR]) |-> scl_oe);

    // R6
    pending_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && $past(pend) && en && !ovr) |-> scl_oe);

    // R6
    write_ones_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_STAT && reg_wdata[STAT_W-1:0] == '1 && eng_set == '0)
        |=> $stable(status_o));

    // R7
    stop_flag_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[S_STOP]) |-> (!scl_oe && !sda_oe));

    // R11
    arb_lost_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[S_ARB]) |-> (!scl_oe && !sda_oe));

    // R12
    override_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !reg_we) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R13
    clear_ctrl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && reg_wdata == '0) |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_reg_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .status_o(status_o), .scl_oe(scl_oe), .sda_oe(sda_oe), .en(c_en), .ovr(c_ovr),
    .eng_set(eng_set)
);

// File: tb/i2c_reg_master_tb.sv
// Bench for the I2C master: behavioural target on an open-drain bus,
// directed corner cases plus seeded random write and read transfers.
module i2c_reg_master_tb;
    localparam logic [6:0] SLV = 7'h50;
    localparam logic [7:0] K_EN = 8'h08, K_GO = 8'h01, K_STP = 8'h02, K_OVR = 8'h10;
    localparam logic [7:0] K_SCL = 8'h40, K_SDA = 8'h20;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic scl_oe, sda_oe;
    logic [6:0] status_o;
    logic [7:0] data_o;
    logic slv_low = 1'b0, arb_force = 1'b0;
    wire  scl_w = ~scl_oe;
    wire  sda_w = ~(sda_oe | slv_low | arb_force);

    int nchk = 0, nerr = 0, tcnt = 0;
    bit done = 0;

    i2c_reg_master u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .status_o(status_o), .data_o(data_o)
    );

    always #5 clk = ~clk;

    // Quarter-bit tick every third cycle
    always @(negedge clk) begin
        if (tcnt == 2) begin tcnt = 0; tick = 1'b1; end
        else begin tcnt = tcnt + 1; tick = 1'b0; end
    end

    // Behavioural target device
    int bc = 0, starts = 0, stops = 0;
    bit active = 0, addrph = 0, reading = 0, mnack = 0;
    logic [7:0] sh = '0, got = '0, slv_tx = '0;

    always @(negedge sda_w) if (scl_w) begin
        starts = starts + 1; active = 1; addrph = 1; reading = 0;
        mnack = 0; bc = -1; slv_low = 1'b0;
    end
    always @(posedge sda_w) if (scl_w) begin
        stops = stops + 1; active = 0; slv_low = 1'b0;
    end
    always @(posedge scl_w) if (active) begin
        if (bc >= 0 && bc < 8) sh = {sh[6:0], sda_w};
        else if (bc == 8 && reading && !addrph) mnack = sda_w;
    end
    always @(negedge scl_w) if (active) begin
        bc = bc + 1;
        if (bc == 9) begin bc = 0; addrph = 0; slv_low = 1'b0; end
        if (addrph) begin
            if (bc == 8) begin
                if (sh[7:1] == SLV) begin slv_low = 1'b1; reading = sh[0]; end
                else active = 0;
            end else slv_low = 1'b0;
        end else if (reading) begin
            if (bc == 0 && mnack) begin slv_low = 1'b0; active = 0; end
            else if (bc < 8) slv_low = !slv_tx[7-bc];
            else slv_low = 1'b0;
        end else begin
            if (bc == 8) begin got = sh; slv_low = 1'b1; end
            else slv_low = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nerr = nerr + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wait_stat(input string req, input logic [6:0] m);
        int n = 0;
        while ((status_o & m) != m && n < 6000) begin @(negedge clk); n = n + 1; end
        nchk = nchk + 1;
        if ((status_o & m) != m) begin
            nerr = nerr + 1;
            $display("FAIL %s: status %0h never showed %0h", req, status_o, m);
        end
    endtask

    task automatic cleanup();
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic do_write(input logic [7:0] d);
        int s0;
        wr(2'd3, d); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'h00);
        s0 = starts;
        wr(2'd0, K_EN | K_GO);
        wait_stat("R4", 7'h09);
        check("R4 write address flags", status_o, 7'h09);
        check("R4 scl held", scl_oe, 1'b1);
        wr(2'd1, 8'h7F);
        repeat (40) @(negedge clk);
        check("R6 ones keep status", status_o, 7'h09);
        check("R6 scl still held", scl_oe, 1'b1);
        wr(2'd0, K_EN);
        wr(2'd1, 8'h76);
        wait_stat("R5", 7'h0C);
        check("R5 sent and empty", status_o, 7'h0C);
        check("R3 byte on bus", got, d);
        check("R8 no extra start", starts, s0 + 1);
        wr(2'd0, K_EN | K_STP);
        wr(2'd1, 8'h77);
        wait_stat("R7", 7'h10);
        check("R7 stop flag", status_o, 7'h14);
        check("R7 stop on bus", (stops > 0), 1'b1);
        check("R7 lines released", {scl_oe, sda_oe}, 2'b00);
        cleanup();
    endtask

    task automatic do_read(input logic [7:0] regb, input logic [7:0] txb);
        int s0, p0;
        slv_tx = txb;
        wr(2'd3, regb); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'h00);
        wr(2'd0, K_EN | K_GO);
        wait_stat("R4", 7'h09);
        wr(2'd0, K_EN);
        wr(2'd1, 8'h76);
        wait_stat("R5", 7'h0C);
        check("R3 register byte", got, regb);
        wr(2'd2, {SLV, 1'b1});
        wr(2'd0, K_EN | K_GO);
        s0 = starts; p0 = stops;
        wr(2'd1, 8'h00);
        wait_stat("R8", 7'h03);
        check("R8 repeated start", starts, s0 + 1);
        check("R8 no stop before restart", stops, p0);
        check("R4 read address flags", status_o, 7'h03);
        wr(2'd0, K_EN | K_STP);
        wr(2'd1, 8'h00);
        wait_stat("R9", 7'h02);
        check("R9 received byte", data_o, txb);
        check("R9 last byte nacked", mnack, 1'b1);
        wr(2'd1, 8'h00);
        wait_stat("R9", 7'h10);
        check("R9 stop after nack", status_o, 7'h10);
        cleanup();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr = nerr + 1; nchk = nchk + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int s0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status reset", status_o, 7'h00);
        check("R1 data reset", data_o, 8'h00);
        check("R1 lines released", {scl_oe, sda_oe}, 2'b00);

        // Directed transfers
        do_write(8'hA5);
        do_read(8'h12, 8'h3C);

        // NACK on address
        wr(2'd2, {7'h23, 1'b0}); wr(2'd1, 8'h00);
        wr(2'd0, K_EN | K_GO);
        wait_stat("R10", 7'h10);
        check("R10 nack then stop", status_o, 7'h50);
        cleanup();

        // Arbitration loss
        wr(2'd2, {7'h7F, 1'b0}); wr(2'd1, 8'h00);
        s0 = starts;
        wr(2'd0, K_EN | K_GO);
        wait (starts == s0 + 1);
        arb_force = 1'b1;
        repeat (300) @(negedge clk);
        check("R11 arbitration flag only", status_o, 7'h20);
        check("R11 lines released", {scl_oe, sda_oe}, 2'b00);
        arb_force = 1'b0;
        cleanup();

        // Abort via control clear
        wr(2'd3, 8'hFF); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'h00);
        s0 = starts;
        wr(2'd0, K_EN | K_GO);
        wait (starts == s0 + 1);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h00);
        check("R13 released at once", {scl_oe, sda_oe}, 2'b00);
        repeat (300) @(negedge clk);
        check("R13 no later flags", status_o, 7'h00);
        cleanup();

        // Pin override combinations
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, K_OVR | (k[0] ? K_SCL : 8'h00) | (k[1] ? K_SDA : 8'h00));
            check("R12 override pins", {scl_oe, sda_oe}, {~k[0], ~k[1]});
        end
        wr(2'd0, 8'h84 | K_OVR | K_SDA);
        check("R2 bits 7 and 2 ignored", {scl_oe, sda_oe}, 2'b10);
        wr(2'd0, K_OVR | K_SCL | K_SDA | K_EN | K_GO);
        repeat (300) @(negedge clk);
        check("R12 engine frozen", {status_o, scl_oe, sda_oe}, 9'h000);
        cleanup();

        // Seeded random transfers
        for (int i = 0; i < 4; i++) do_write(8'($urandom));
        for (int i = 0; i < 3; i++) do_read(8'($urandom), 8'($urandom));

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule